// File: doc/BRIEF.md
# Dual-Mode Binary/Decimal Nibble ALU

This block is the arithmetic and logic core of a narrow datapath. Each cycle it takes two operand buses, gates and conditions them, and performs one of eight operations selected by a 3-bit code. The operations are five additions that differ in carry-in and carry saving, a bitwise AND, a bitwise XOR, and an XOR whose result is shifted right by one place. A mode input selects pure binary arithmetic or packed-decimal (BCD) arithmetic. In decimal mode, sums above nine are corrected by adding six.

The result, a zero flag and a transient carry are combinational outputs. A single saved-carry flop keeps the carry across cycles so that multi-digit additions can be chained one digit per cycle. The flop is written only by the operations that save the carry, and only when the cycle-enable input is high. Bus source selection, destination routing and the register file sit outside this block.

Top module: `dual_mode_alu`

## Requirements
- R1: When `a_gate` is 0 the A operand is 0000 whatever `a_bus` holds; when it is 1 the A operand is `a_bus`.
- R2: `b_cond` selects the B operand: 00 gives 0000, 01 gives `b_bus`, 10 gives 1111 in binary mode and 1001 in decimal mode.
- R3: `b_cond` = 11 complements B: the bitwise inverse in binary mode and (9 - B) modulo 16 in decimal mode.
- R4: `op_code` selects the add: 000 adds A+B, 001 adds A+B+1, 010 adds A+B, 011 adds A+B+saved carry, and 100 adds A+B+1. In binary mode (`dec_mode`=0) `result` is the sum modulo 16 and `carry_out` is bit 4 of the sum.
- R5: In decimal mode (`dec_mode`=1), for an add whose 5-bit raw sum exceeds 9, `result` is (raw+6) modulo 16 and `carry_out` is 1. Otherwise `result` is the raw sum and `carry_out` is 0.
- R6: `op_code` 101 gives A AND B and `op_code` 110 gives A XOR B, with `carry_out` 0 in both cases.
- R7: `op_code` 111 gives (A XOR B) shifted right one bit with 0 entering the top bit, and `carry_out` equals bit 0 of A XOR B.
- R8: `zero` is 1 exactly when `result` is 0000.
- R9: `saved_carry` takes the value of `carry_out` at a rising clock edge only when `cyc_en` is 1 and `op_code` is 010, 011, 100 or 111; otherwise it holds.
- R10: Operation 011 uses the current `saved_carry` as its carry-in.
- R11: An active-low `rst_n` clears `saved_carry` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Cycle enable for the saved-carry flop |
| op_code | input | 3 | Operation select |
| a_bus | input | 4 | A operand bus |
| b_bus | input | 4 | B operand bus |
| a_gate | input | 1 | 1 passes A, 0 forces zero |
| b_cond | input | 2 | B conditioning select |
| dec_mode | input | 1 | 0 binary, 1 decimal |
| result | output | 4 | Operation result |
| zero | output | 1 | Result is zero |
| carry_out | output | 1 | Carry of the current operation |
| saved_carry | output | 1 | Stored carry |

## Verification
The only internal state is the saved-carry flop. A wrong value there appears at the `saved_carry` port one clock edge after the faulty update. It also changes `result` and `carry_out` of the very next 011 addition. The bench therefore sweeps every combination of the combinational inputs under both saved-carry values, and compares each output against an arithmetic model. Directed clocked sequences then show that enables and non-saving codes leave the flop untouched, checked at the port after each edge.

// File: rtl/nalu_pkg.sv
package nalu_pkg;

   typedef enum logic [2:0] {
      OP_ADD     = 3'b000,
      OP_ADD_INC = 3'b001,
      OP_ADD_SC  = 3'b010,
      OP_ADC_SC  = 3'b011,
      OP_INC_SC  = 3'b100,
      OP_AND     = 3'b101,
      OP_XOR     = 3'b110,
      OP_XSR     = 3'b111
   } alu_op_e;

   typedef enum logic [1:0] {
      BC_ZERO = 2'b00,
      BC_PASS = 2'b01,
      BC_MAX  = 2'b10,
      BC_CMPL = 2'b11
   } bcond_e;

   function automatic logic is_add(alu_op_e op);
      return (op == OP_ADD) || (op == OP_ADD_INC) || (op == OP_ADD_SC) ||
             (op == OP_ADC_SC) || (op == OP_INC_SC);
   endfunction

   function automatic logic saves_carry(alu_op_e op);
      return (op == OP_ADD_SC) || (op == OP_ADC_SC) || (op == OP_INC_SC) ||
             (op == OP_XSR);
   endfunction

endpackage

// File: rtl/nalu_operand.sv
module nalu_operand #(
   parameter int DATA_W = 4,
   parameter bit DEC_EN = 1'b1
) (
   input  logic [DATA_W-1:0] a_bus,
   input  logic [DATA_W-1:0] b_bus,
   input  logic              a_gate,
   input  logic [1:0]        b_cond,
   input  logic              dec_mode,
   output logic [DATA_W-1:0] a_opnd,
   output logic [DATA_W-1:0] b_opnd
);
   import nalu_pkg::*;

   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
   localparam logic [DATA_W-1:0] DEC_TOP  = DATA_W'(9);

   logic [DATA_W-1:0] b_max;
   logic [DATA_W-1:0] b_cmp;
   bcond_e            cond;

   assign cond   = bcond_e'(b_cond);
   assign a_opnd = a_gate ? a_bus : '0;

   generate
      if (DEC_EN) begin : g_dec
         assign b_max = dec_mode ? DEC_TOP : ALL_ONES;
         assign b_cmp = dec_mode ? (DEC_TOP - b_bus) : ~b_bus;
      end else begin : g_bin
         logic unused_mode;
         assign unused_mode = dec_mode;
         assign b_max = ALL_ONES;
         assign b_cmp = ~b_bus;
      end
   endgenerate

   always_comb begin
      unique case (cond)
         BC_ZERO: b_opnd = '0;
         BC_PASS: b_opnd = b_bus;
         BC_MAX:  b_opnd = b_max;
         BC_CMPL: b_opnd = b_cmp;
         default: b_opnd = '0;
      endcase
   end

endmodule

// File: rtl/nalu_adder.sv
module nalu_adder #(
   parameter int DATA_W = 4,
   parameter bit DEC_EN = 1'b1
) (
   input  logic [DATA_W-1:0] a_opnd,
   input  logic [DATA_W-1:0] b_opnd,
   input  logic              cin,
   input  logic              dec_mode,
   output logic [DATA_W-1:0] sum,
   output logic              cout
);
   localparam int SUM_W = DATA_W + 1;

   logic [SUM_W-1:0] raw;

   assign raw = {1'b0, a_opnd} + {1'b0, b_opnd} + {{DATA_W{1'b0}}, cin};

   generate
      if (DEC_EN) begin : g_dec
         logic             over_nine;
         logic [SUM_W-1:0] fixed;
         assign over_nine = raw > SUM_W'(9);
         assign fixed     = raw + SUM_W'(6);
         assign sum  = (dec_mode && over_nine) ? fixed[DATA_W-1:0] : raw[DATA_W-1:0];
         assign cout = dec_mode ? over_nine : raw[DATA_W];
      end else begin : g_bin
         logic unused_mode;
         assign unused_mode = dec_mode;
         assign sum  = raw[DATA_W-1:0];
         assign cout = raw[DATA_W];
      end
   endgenerate

endmodule

// File: rtl/nalu_logic.sv
module nalu_logic #(
   parameter int DATA_W = 4
) (
   input  logic [DATA_W-1:0] a_opnd,
   input  logic [DATA_W-1:0] b_opnd,
   input  logic [2:0]        op_code,
   output logic [DATA_W-1:0] res,
   output logic              cout
);
   import nalu_pkg::*;

   logic [DATA_W-1:0] mix;
   alu_op_e           op;

   assign op  = alu_op_e'(op_code);
   assign mix = a_opnd ^ b_opnd;

   always_comb begin
      res  = mix;
      cout = 1'b0;
      unique case (op)
         OP_AND: res = a_opnd & b_opnd;
         OP_XOR: res = mix;
         OP_XSR: begin
            res  = {1'b0, mix[DATA_W-1:1]};
            cout = mix[0];
         end
         default: res = mix;
      endcase
   end

endmodule

// File: rtl/dual_mode_alu.sv
module dual_mode_alu #(
   parameter int DATA_W = 4,
   parameter bit DEC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_en,
   input  logic [2:0]        op_code,
   input  logic [DATA_W-1:0] a_bus,
   input  logic [DATA_W-1:0] b_bus,
   input  logic              a_gate,
   input  logic [1:0]        b_cond,
   input  logic              dec_mode,
   output logic [DATA_W-1:0] result,
   output logic              zero,
   output logic              carry_out,
   output logic              saved_carry
);
   import nalu_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dual_mode_alu: DATA_W must be at least 2");
      end
      if (DEC_EN && DATA_W != 4) begin : g_bad_dec
         $error("dual_mode_alu: decimal mode needs DATA_W of 4");
      end
   endgenerate

   alu_op_e           op;
   logic [DATA_W-1:0] a_opnd, b_opnd;
   logic [DATA_W-1:0] add_sum, log_res;
   logic              add_cout, log_cout, add_cin;
   logic              sc_q;

   assign op = alu_op_e'(op_code);

   nalu_operand #(.DATA_W(DATA_W), .DEC_EN(DEC_EN)) opnd_i (
      .a_bus    (a_bus),
      .b_bus    (b_bus),
      .a_gate   (a_gate),
      .b_cond   (b_cond),
      .dec_mode (dec_mode),
      .a_opnd   (a_opnd),
      .b_opnd   (b_opnd)
   );

   always_comb begin
      unique case (op)
         OP_ADD_INC, OP_INC_SC: add_cin = 1'b1;
         OP_ADC_SC:             add_cin = sc_q;
         default:               add_cin = 1'b0;
      endcase
   end

   nalu_adder #(.DATA_W(DATA_W), .DEC_EN(DEC_EN)) add_i (
      .a_opnd   (a_opnd),
      .b_opnd   (b_opnd),
      .cin      (add_cin),
      .dec_mode (dec_mode),
      .sum      (add_sum),
      .cout     (add_cout)
   );

   nalu_logic #(.DATA_W(DATA_W)) log_i (
      .a_opnd  (a_opnd),
      .b_opnd  (b_opnd),
      .op_code (op_code),
      .res     (log_res),
      .cout    (log_cout)
   );

   assign result    = is_add(op) ? add_sum  : log_res;
   assign carry_out = is_add(op) ? add_cout : log_cout;
   assign zero      = ~|result;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_q <= 1'b0;
      end else if (cyc_en && saves_carry(op)) begin
         sc_q <= carry_out;
      end
   end

   assign saved_carry = sc_q;

endmodule

// File: rtl/nalu_chk.sv
module nalu_chk #(
   parameter int DATA_W = 4,
   parameter bit DEC_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_en,
   input logic [2:0]        op_code,
   input logic [DATA_W-1:0] a_bus,
   input logic [DATA_W-1:0] b_bus,
   input logic              a_gate,
   input logic [1:0]        b_cond,
   input logic              dec_mode,
   input logic [DATA_W-1:0] result,
   input logic              zero,
   input logic              carry_out,
   input logic              saved_carry
);

   logic saving;
   assign saving = (op_code == 3'b010) || (op_code == 3'b011) ||
                   (op_code == 3'b100) || (op_code == 3'b111);

   // R9: an enabled saving operation stores the carry
   a_r9_sc_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_en && saving) |=> (saved_carry == $past(carry_out)));

   // R9: no enable, or a non-saving code, leaves the flop alone
   a_r9_sc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_en || !saving) |=> $stable(saved_carry));

   // R7: the shift fills the top bit with zero
   a_r7_msb_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 3'b111) |-> !result[DATA_W-1]);

   // R6: logical operations give no carry
   a_r6_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 3'b101 || op_code == 3'b110) |-> !carry_out);

   // R1, R8: AND with a gated-off A is zero
   a_r8_zero_and: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 3'b101 && !a_gate) |-> (zero && result == '0));

   // R2: forcing B to zero with A gated off passes the carry-in only
   a_r2_zero_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 3'b000 && !a_gate && b_cond == 2'b00) |-> (zero && !carry_out));

   generate
      if (DEC_EN) begin : g_dec
         // R5: valid decimal digits give a valid decimal digit
         a_r5_dec_digit: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_mode && op_code <= 3'b100 && a_bus <= DATA_W'(9) && b_bus <= DATA_W'(9))
            |-> (result <= DATA_W'(9)));
      end
   endgenerate

endmodule

bind dual_mode_alu nalu_chk #(.DATA_W(DATA_W), .DEC_EN(DEC_EN)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cyc_en      (cyc_en),
   .op_code     (op_code),
   .a_bus       (a_bus),
   .b_bus       (b_bus),
   .a_gate      (a_gate),
   .b_cond      (b_cond),
   .dec_mode    (dec_mode),
   .result      (result),
   .zero        (zero),
   .carry_out   (carry_out),
   .saved_carry (saved_carry)
);

// File: tb/dual_mode_alu_tb_top.sv
module dual_mode_alu_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_en = 1'b0;
   logic [2:0] op_code = 3'd0;
   logic [3:0] a_bus = 4'd0;
   logic [3:0] b_bus = 4'd0;
   logic       a_gate = 1'b0;
   logic [1:0] b_cond = 2'd0;
   logic       dec_mode = 1'b0;
   logic [3:0] result;
   logic       zero, carry_out, saved_carry;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_mode_alu #(.DATA_W(4), .DEC_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .op_code(op_code),
      .a_bus(a_bus), .b_bus(b_bus), .a_gate(a_gate), .b_cond(b_cond),
      .dec_mode(dec_mode), .result(result), .zero(zero),
      .carry_out(carry_out), .saved_carry(saved_carry)
   );

   // returns {carry, result}
   function automatic logic [4:0] model(int op, int a, int b, int g, int c, int d, int sc);
      int ae, be, s, r, co, x;
      ae = g ? a : 0;
      case (c)
         0: be = 0;
         1: be = b;
         2: be = d ? 9 : 15;
         default: be = d ? ((9 - b) & 15) : (~b & 15);
      endcase
      r = 0; co = 0;
      if (op <= 4) begin
         s = ae + be + ((op == 1 || op == 4) ? 1 : (op == 3 ? sc : 0));
         if (d != 0) begin
            if (s > 9) begin r = (s + 6) & 15; co = 1; end
            else begin r = s; co = 0; end
         end else begin
            r = s & 15; co = (s >> 4) & 1;
         end
      end else if (op == 5) begin
         r = ae & be;
      end else if (op == 6) begin
         r = ae ^ be;
      end else begin
         x = ae ^ be; r = x >> 1; co = x & 1;
      end
      return {co[0], r[3:0]};
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (op=%0d a=%0d b=%0d g=%0d c=%0d d=%0d)",
                  tag, act, exp, op_code, a_bus, b_bus, a_gate, b_cond, dec_mode);
      end
   endtask

   task automatic drive(int op, int a, int b, int g, int c, int d);
      op_code = op[2:0]; a_bus = a[3:0]; b_bus = b[3:0];
      a_gate = g[0]; b_cond = c[1:0]; dec_mode = d[0];
   endtask

   task automatic clock_op(int op, int a, int b, int g, int c, int d, int en);
      @(negedge clk);
      drive(op, a, b, g, c, d);
      cyc_en = en[0];
      @(posedge clk);
      #1;
      cyc_en = 1'b0;
   endtask

   task automatic set_sc(int v);
      if (v != 0) clock_op(2, 15, 1, 1, 1, 0, 1);
      else        clock_op(2, 0, 0, 1, 1, 0, 1);
      check("R9 set saved carry", saved_carry, v);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [4:0] exp;
      string      tag;
      repeat (3) @(posedge clk);
      #1;
      check("R11 saved carry after reset", saved_carry, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R11 saved carry out of reset", saved_carry, 0);

      // directed cases
      drive(0, 7, 5, 0, 0, 0); #1;
      check("R1 gated A gives zero", result, 0);
      drive(0, 7, 0, 1, 0, 0); #1;
      check("R1 open gate passes A", result, 7);
      drive(0, 3, 6, 0, 2, 1); #1;
      check("R2 decimal max is 9", result, 9);
      drive(0, 3, 6, 0, 2, 0); #1;
      check("R2 binary max is 15", result, 15);
      drive(0, 0, 3, 0, 3, 1); #1;
      check("R3 nines complement of 3", result, 6);
      drive(0, 0, 3, 0, 3, 0); #1;
      check("R3 inverse of 3", result, 12);
      drive(0, 8, 7, 1, 1, 1); #1;
      check("R5 8+7 decimal", result, 5);
      check("R5 8+7 decimal carry", carry_out, 1);
      drive(7, 5, 0, 1, 0, 0); #1;
      check("R7 shift of 0101", result, 2);
      check("R7 shift carry", carry_out, 1);

      // R9: non-saving codes and disabled cycles hold the flop
      set_sc(1);
      clock_op(0, 0, 0, 1, 1, 0, 1);
      check("R9 add without save holds", saved_carry, 1);
      clock_op(5, 0, 0, 1, 1, 0, 1);
      check("R9 AND holds", saved_carry, 1);
      clock_op(2, 0, 0, 1, 1, 0, 0);
      check("R9 disabled cycle holds", saved_carry, 1);
      drive(3, 0, 0, 0, 0, 0); #1;
      check("R10 carry-in from saved carry", result, 1);
      clock_op(3, 0, 0, 0, 0, 0, 1);
      check("R9 R10 op 011 stores zero carry", saved_carry, 0);
      clock_op(7, 1, 0, 1, 0, 0, 1);
      check("R9 shift stores lost bit", saved_carry, 1);
      clock_op(4, 15, 0, 1, 1, 0, 1);
      check("R9 op 100 stores carry", saved_carry, 1);
      clock_op(4, 3, 0, 1, 1, 0, 1);
      check("R9 op 100 stores no carry", saved_carry, 0);
      clock_op(6, 15, 15, 1, 1, 0, 1);
      check("R9 XOR holds", saved_carry, 0);

      // exhaustive combinational sweep under both saved-carry values
      for (int sc = 0; sc < 2; sc++) begin
         set_sc(sc);
         for (int op = 0; op < 8; op++)
            for (int d = 0; d < 2; d++)
               for (int c = 0; c < 4; c++)
                  for (int g = 0; g < 2; g++)
                     for (int a = 0; a < 16; a++)
                        for (int b = 0; b < 16; b++) begin
                           drive(op, a, b, g, c, d);
                           #1;
                           exp = model(op, a, b, g, c, d, sc);
                           if (op >= 5 && op <= 6) tag = "R6";
                           else if (op == 7) tag = "R7";
                           else if (d != 0) tag = "R5";
                           else if (op == 3) tag = "R10";
                           else tag = "R4";
                           check({tag, " result/carry"}, {carry_out, result}, exp);
                           check("R8 zero flag", zero, (exp[3:0] == 4'd0) ? 1 : 0);
                        end
         #1;
         check("R9 sweep leaves saved carry", saved_carry, sc);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule